// File: doc/BRIEF.md
# Three-Phase Bridge Gate Interlock

This block sits between a commutation decoder and the gate drivers of a three-phase half-bridge. Each phase gets a high-side and a low-side drive request. The block turns those six requests into six registered gate commands. High-side commands are active low and low-side commands are active high.

On the way to the gates, each request is shaped by the state of the PWM latch. A mode select picks two-quadrant or four-quadrant chopping. A brake input overrides the decoder and turns on every low-side switch. Fault inputs blank every output. A dead-time interlock then decides the final gate state. It keeps one busy flag per output, and that flag stays set from the moment the output turns on until two PWM oscillator ticks have passed after it turns off. While the flag is set, the opposite switch on the same phase may not turn on.

The PWM tick is a single-cycle pulse, one per oscillator period. Bit i of every three-bit bus belongs to phase i.

Top module: `bridge_gate`

## Requirements
- R1: During and right after reset, every high-side output reads 1 (off) and every low-side output reads 0 (off).
- R2: Two-quadrant mode (quad4 = 0, brake = 0) works as follows. A low-side request drives pd high only while pwm_on = 1 and peak_lim = 0. A high-side request drives pu_n low regardless of pwm_on.
- R3: In four-quadrant mode (quad4 = 1, brake = 0), both the high-side and the low-side requests reach the outputs only while pwm_on = 1 and peak_lim = 0.
- R4: peak_lim = 1 chops exactly as pwm_on = 0 does, in every mode including brake.
- R5: With brake = 1, the outputs are as follows, and quad4 has no effect:
  - all high-side outputs are off (pu_n = 111);
  - all low-side outputs are on (pd = 111) while pwm_on = 1 and peak_lim = 0;
  - the decoder requests are ignored.
- R6: When uvlo, ocp or coast is 1, all six outputs are off from the next clock edge, in any mode.
- R7: Outside brake, a phase whose high-side and low-side requests are both 1 drives neither of its switches.
- R8: An output turns on only after its opposite on the same phase has been off and two pwm_tick pulses have been counted since then. Without ticks, the opposite stays blocked indefinitely. This also holds when brake turns on a low side.
- R9: The high-side and low-side switches of one phase are never commanded on in the same cycle.
- R10: When no interlock is holding an output, it follows a change of the inputs one clock edge later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_hi | input | 3 | High-side drive requests from the decoder, active high |
| req_lo | input | 3 | Low-side drive requests from the decoder, active high |
| pwm_on | input | 1 | PWM latch state; 1 allows chopped drives to conduct |
| peak_lim | input | 1 | Peak current limit; 1 chops like an off PWM latch |
| pwm_tick | input | 1 | One-cycle pulse per PWM oscillator period |
| quad4 | input | 1 | 0 selects two-quadrant chopping, 1 four-quadrant |
| brake | input | 1 | 1 selects brake mode |
| uvlo | input | 1 | Undervoltage lockout, 1 blanks all outputs |
| ocp | input | 1 | Over-current shutdown, 1 blanks all outputs |
| coast | input | 1 | Coast or overvoltage command, 1 blanks all outputs |
| pu_n | output | 3 | High-side gate commands, active low |
| pd | output | 3 | Low-side gate commands, active high |

## Verification
The gating is first walked through steady-state patterns that combine the following:
- high and low requests on different phases;
- both quadrant settings with the PWM latch open and closed;
- peak limit alone;
- brake with each quadrant setting;
- each fault alone and on top of brake.

These patterns tell apart three behaviours:
- a chop that reaches only the low side;
- a chop that reaches both sides;
- a brake that ignores the decoder and the quadrant select.

Patterns with several low switches on at once and with a conflicting phase separate per-phase gating from global gating.

Directed sequences then hand a phase from one side to the other. Samples are taken with no tick, after one tick, and on the exact edges around the second tick, which pins the dead-time count to two ticks and not one or three. The same count is checked when brake takes over from a high side that was on.

// File: rtl/bg_pkg.sv
`timescale 1ns/1ps
package bg_pkg;

  // Gating enable for one side of a phase, before fault blanking.
  function automatic logic side_enable(input logic is_high, input logic quad4,
                                       input logic brake, input logic run_ok);
    logic en;
    if (brake)        en = is_high ? 1'b0 : run_ok;
    else if (is_high) en = quad4 ? run_ok : 1'b1;
    else              en = run_ok;
    return en;
  endfunction

  // True when the tick being counted is the last one of the dead time.
  function automatic logic tick_done(input int unsigned count, input int unsigned limit);
    return (count + 1) >= limit;
  endfunction

endpackage

// File: rtl/bg_req_gate.sv
`timescale 1ns/1ps
module bg_req_gate #(
  parameter int PHASES = 3
) (
  input  logic [PHASES-1:0] req_hi,
  input  logic [PHASES-1:0] req_lo,
  input  logic              pwm_on,
  input  logic              peak_lim,
  input  logic              quad4,
  input  logic              brake,
  input  logic              uvlo,
  input  logic              ocp,
  input  logic              coast,
  output logic [PHASES-1:0] want_hi,
  output logic [PHASES-1:0] want_lo,
  output logic              kill,
  output logic              run_ok
);

  logic en_hi;
  logic en_lo;
  logic [PHASES-1:0] conflict;

  assign kill   = uvlo | ocp | coast;
  assign run_ok = pwm_on & ~peak_lim;
  assign en_hi  = bg_pkg::side_enable(1'b1, quad4, brake, run_ok);
  assign en_lo  = bg_pkg::side_enable(1'b0, quad4, brake, run_ok);

  always_comb begin
    for (int i = 0; i < PHASES; i++) begin
      conflict[i] = ~brake & req_hi[i] & req_lo[i];
      want_hi[i]  = ~kill & ~conflict[i] & req_hi[i] & en_hi;
      want_lo[i]  = ~kill & ~conflict[i] & (brake | req_lo[i]) & en_lo;
    end
  end

endmodule

// File: rtl/bg_leg.sv
`timescale 1ns/1ps
module bg_leg #(
  parameter int DEAD_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic want,
  input  logic partner_busy,
  output logic on_q,
  output logic busy
);

  localparam int CNT_W = (DEAD_TICKS > 1) ? $clog2(DEAD_TICKS) : 1;

  logic             flag_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last_tick;

  assign last_tick = bg_pkg::tick_done(int'(cnt_q), DEAD_TICKS);
  assign busy      = on_q | flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q   <= 1'b0;
      flag_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      on_q <= want & ~partner_busy;
      if (on_q) begin
        flag_q <= 1'b1;
        cnt_q  <= '0;
      end else if (flag_q && tick) begin
        if (last_tick) begin
          flag_q <= 1'b0;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R8: the flag is only released on a counted tick
  assert_flag_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(tick));

  // R8: turn-on only when the opposite side was idle
  assert_turn_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(on_q) |-> $past(!partner_busy));

endmodule

// File: rtl/bridge_gate.sv
`timescale 1ns/1ps
module bridge_gate #(
  parameter int PHASES     = 3,
  parameter int DEAD_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PHASES-1:0] req_hi,
  input  logic [PHASES-1:0] req_lo,
  input  logic              pwm_on,
  input  logic              peak_lim,
  input  logic              pwm_tick,
  input  logic              quad4,
  input  logic              brake,
  input  logic              uvlo,
  input  logic              ocp,
  input  logic              coast,
  output logic [PHASES-1:0] pu_n,
  output logic [PHASES-1:0] pd
);

  logic [PHASES-1:0] want_hi;
  logic [PHASES-1:0] want_lo;
  logic [PHASES-1:0] hi_on;
  logic [PHASES-1:0] lo_on;
  logic [PHASES-1:0] hi_busy;
  logic [PHASES-1:0] lo_busy;
  logic              kill;
  logic              run_ok;

  bg_req_gate #(.PHASES(PHASES)) u_gate (
    .req_hi   (req_hi),
    .req_lo   (req_lo),
    .pwm_on   (pwm_on),
    .peak_lim (peak_lim),
    .quad4    (quad4),
    .brake    (brake),
    .uvlo     (uvlo),
    .ocp      (ocp),
    .coast    (coast),
    .want_hi  (want_hi),
    .want_lo  (want_lo),
    .kill     (kill),
    .run_ok   (run_ok)
  );

  for (genvar p = 0; p < PHASES; p++) begin : g_phase
    bg_leg #(.DEAD_TICKS(DEAD_TICKS)) u_hi (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick         (pwm_tick),
      .want         (want_hi[p]),
      .partner_busy (lo_busy[p]),
      .on_q         (hi_on[p]),
      .busy         (hi_busy[p])
    );
    bg_leg #(.DEAD_TICKS(DEAD_TICKS)) u_lo (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick         (pwm_tick),
      .want         (want_lo[p]),
      .partner_busy (hi_busy[p]),
      .on_q         (lo_on[p]),
      .busy         (lo_busy[p])
    );
  end

  assign pu_n = ~hi_on;
  assign pd   = lo_on;

  // R9: never both switches of a phase at once
  assert_no_shoot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_on & lo_on) == '0);

  // R6: any fault blanks every output on the next edge
  assert_fault_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> (hi_on == '0 && lo_on == '0));

  // R5: brake leaves all high sides off
  assert_brake_high_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    brake |=> (hi_on == '0));

  // R4: a closed PWM latch or the peak limit stops every low side
  assert_chop_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !run_ok |=> (lo_on == '0));

  // R3: four-quadrant chop also stops every high side
  assert_chop_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_ok && quad4) |=> (hi_on == '0));

endmodule

// File: tb/sim_bridge_gate.sv
`timescale 1ns/1ps
module sim_bridge_gate;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] req_hi = '0;
  logic [2:0] req_lo = '0;
  logic       pwm_on = 1'b0;
  logic       peak_lim = 1'b0;
  logic       pwm_tick = 1'b0;
  logic       quad4 = 1'b0;
  logic       brake = 1'b0;
  logic       uvlo = 1'b0;
  logic       ocp = 1'b0;
  logic       coast = 1'b0;
  logic [2:0] pu_n;
  logic [2:0] pd;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bridge_gate u0 (
    .clk(clk), .rst_n(rst_n), .req_hi(req_hi), .req_lo(req_lo),
    .pwm_on(pwm_on), .peak_lim(peak_lim), .pwm_tick(pwm_tick),
    .quad4(quad4), .brake(brake), .uvlo(uvlo), .ocp(ocp), .coast(coast),
    .pu_n(pu_n), .pd(pd)
  );

  // Vector layout: hi[22:20] lo[19:17] pwm peak q4 brk uv oc cst [16:10]
  //                exp_pu_n[9:7] exp_pd[6:4] req number[3:0]
  localparam int NV = 17;
  localparam logic [22:0] VEC [NV] = '{
    {3'b001, 3'b010, 7'b1000000, 3'b110, 3'b010, 4'd2},  // R2 open latch
    {3'b001, 3'b010, 7'b0000000, 3'b110, 3'b000, 4'd2},  // R2 chop low only
    {3'b001, 3'b010, 7'b0010000, 3'b111, 3'b000, 4'd3},  // R3 chop both
    {3'b001, 3'b010, 7'b1010000, 3'b110, 3'b010, 4'd3},  // R3 open latch
    {3'b001, 3'b010, 7'b1100000, 3'b110, 3'b000, 4'd4},  // R4 peak, 2Q
    {3'b100, 3'b001, 7'b1110000, 3'b111, 3'b000, 4'd4},  // R4 peak, 4Q
    {3'b010, 3'b100, 7'b1000000, 3'b101, 3'b100, 4'd2},  // R2 other phases
    {3'b010, 3'b100, 7'b1001000, 3'b111, 3'b111, 4'd5},  // R5 brake 2Q
    {3'b001, 3'b000, 7'b1011000, 3'b111, 3'b111, 4'd5},  // R5 brake 4Q
    {3'b001, 3'b000, 7'b0001000, 3'b111, 3'b000, 4'd5},  // R5 brake, latch closed
    {3'b000, 3'b000, 7'b1101000, 3'b111, 3'b000, 4'd4},  // R4 brake with peak
    {3'b001, 3'b010, 7'b1000100, 3'b111, 3'b000, 4'd6},  // R6 uvlo
    {3'b001, 3'b010, 7'b1000010, 3'b111, 3'b000, 4'd6},  // R6 ocp
    {3'b000, 3'b000, 7'b1001001, 3'b111, 3'b000, 4'd6},  // R6 coast in brake
    {3'b000, 3'b000, 7'b1001100, 3'b111, 3'b000, 4'd6},  // R6 uvlo in brake
    {3'b011, 3'b010, 7'b1000000, 3'b110, 3'b000, 4'd7},  // R7 phase 1 conflict
    {3'b100, 3'b011, 7'b1000000, 3'b011, 3'b011, 4'd2}   // R2 two low sides
  };

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic tick_pulse();
    @(negedge clk) pwm_tick = 1'b1;
    @(negedge clk) pwm_tick = 1'b0;
  endtask

  task automatic settle();
    for (int k = 0; k < 3; k++) begin
      tick_pulse();
      repeat (2) @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic apply(input logic [22:0] v);
    req_hi = v[22:20]; req_lo = v[19:17];
    pwm_on = v[16]; peak_lim = v[15]; quad4 = v[14]; brake = v[13];
    uvlo = v[12]; ocp = v[11]; coast = v[10];
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state, during reset
    check("R1 pu_n in reset", pu_n, 3'b111);
    check("R1 pd in reset", pd, 3'b000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 pu_n after reset", pu_n, 3'b111);
    check("R1 pd after reset", pd, 3'b000);

    // R10 one-edge latency with nothing holding
    req_hi = 3'b001; pwm_on = 1'b1;
    @(negedge clk);
    check("R10 high on after one edge", pu_n, 3'b110);

    // R8 hand phase 0 from high to low side
    req_hi = 3'b000; req_lo = 3'b001;
    @(negedge clk);
    check("R10 high off after one edge", pu_n, 3'b111);
    check("R8 low held at handover", pd, 3'b000);
    repeat (20) @(negedge clk);
    check("R8 low held with no ticks", pd, 3'b000);
    tick_pulse();
    repeat (4) @(negedge clk);
    check("R8 low held after one tick", pd, 3'b000);
    tick_pulse();
    check("R8 low still off at second tick edge", pd, 3'b000);
    @(negedge clk);
    check("R8 low on one edge after second tick", pd, 3'b001);

    // Steady-state table
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      settle();
      check($sformatf("R%0d vector %0d pu_n", VEC[i][3:0], i), pu_n, VEC[i][9:7]);
      check($sformatf("R%0d vector %0d pd", VEC[i][3:0], i), pd, VEC[i][6:4]);
    end

    // R8 brake taking over from an active high side
    apply({3'b001, 3'b000, 7'b1000000, 6'b0, 4'd0});
    settle();
    check("R8 high side on before brake", pu_n, 3'b110);
    brake = 1'b1;
    @(negedge clk);
    check("R8 brake low held on busy phase", pd, 3'b110);
    tick_pulse();
    tick_pulse();
    @(negedge clk);
    check("R8 brake low on after two ticks", pd, 3'b111);

    // R6 fault blanks on the very next edge
    ocp = 1'b1;
    @(negedge clk);
    check("R6 ocp next edge pd", pd, 3'b000);
    check("R6 ocp next edge pu_n", pu_n, 3'b111);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule